// File: doc/BRIEF.md
# Local Bus Burst Master Sequencer

This block runs the master side of a local-bus transfer made of sequential data words. A requester presents a start address, a word count and a per-transfer configuration. The configuration sets burst enable, target-terminate enable, bus width (8, 16 or 32 bits) and a wait-state count. The block then drives an active-low address strobe, an active-low last-beat flag and the current address. It samples the target's active-low ready and terminate inputs to advance from beat to beat.

The block decides where each burst ends and when a fresh address cycle is needed. It splits a long transfer into single beats, into bursts bounded by the width-dependent quad boundary, or into open-ended bursts that the target breaks up. A one-cycle done pulse marks the acknowledge of the final word. The block takes a new request only while it is idle.

Top module: `lbs_burst_seq`

## Requirements
- R1: After reset, `ads_n` and `blast_n` are high and `busy` and `done` are low.
- R2: A request is taken only when the block is idle and `req_beats` is non-zero. `ads_n` goes low in the cycle after the request is taken, with `la` equal to `req_addr`. A request made while busy, or with a zero count, has no effect.
- R3: With burst disabled (`cfg_burst`=0), every beat has its own one-cycle `ads_n` and its own `blast_n`, whatever `cfg_term_en` is.
- R4: With burst enabled and terminate disabled, a burst ends after the beat whose address has both unit-index bits set. This is at most four beats. The next burst starts with a new `ads_n` at the following, quad-aligned address.
- R5: `cfg_width` codes are 0 for an 8-bit bus, 1 for 16-bit and 2 or 3 for 32-bit. The address advances by 1, 2 or 4 per beat. The unit-index bits are `la[1:0]`, `la[2:1]` or `la[3:2]` respectively.
- R6: `blast_n` is low for every cycle of the final data phase of a burst that ends normally. This includes the last beat of the transfer. It is high in every other cycle.
- R7: With burst and terminate both enabled, a single `ads_n` covers all beats until the transfer ends or the target terminates the burst. `blast_n` stays high except on the transfer's last beat.
- R8: When terminate is enabled and `bterm_n` is sampled low in an acknowledge cycle, the beat is acknowledged. If words remain, `ads_n` is low in the next cycle with `la` at the next word's address.
- R9: If `bterm_n` and `ready_n` are both low in the same acknowledge cycle, the terminate behaviour of R8 applies.
- R10: After each address cycle and after each acknowledged beat, the block ignores `ready_n` and `bterm_n` for `cfg_wait` cycles. The first data cycle is the first one sampled when `cfg_wait` is 0.
- R11: With `cfg_term_en`=0, `bterm_n` has no effect and only `ready_n` acknowledges a beat.
- R12: `done` is high for exactly one cycle, the cycle after the final word is acknowledged. In that cycle `busy` is already low. `busy` is high from the cycle after acceptance until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request |
| req_addr | input | AW | Start address of the transfer |
| req_beats | input | CW | Number of words to move |
| cfg_burst | input | 1 | Burst enable |
| cfg_term_en | input | 1 | Target-terminate (continuous burst) enable |
| cfg_width | input | 2 | Bus width code: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| cfg_wait | input | WW | Wait cycles before each acknowledge is sampled |
| ready_n | input | 1 | Target beat acknowledge, active low |
| bterm_n | input | 1 | Target burst terminate, active low |
| ads_n | output | 1 | Address strobe, active low |
| blast_n | output | 1 | Last beat of burst, active low |
| la | output | AW | Local address of the current cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final acknowledge |

## Verification
Every output comes straight from registered state. An input sampled at one rising edge therefore shows its effect on `ads_n`, `blast_n`, `la`, `busy` and `done` right after that same edge: one cycle after a request, one cycle after an acknowledge, and `cfg_wait`+1 data cycles after an address cycle for the earliest acknowledge. The bench keeps a behavioural model that also advances on the rising edge from the same sampled inputs. It compares all five outputs against that model at each falling edge, so each result is checked in exactly the cycle it is due. Inputs change only at falling edges, after the comparison.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } lbs_state_e;

    // Bus width codes; code 3 behaves as 32-bit
    typedef enum logic [1:0] {
        BW_8  = 2'd0,
        BW_16 = 2'd1,
        BW_32 = 2'd2
    } lbs_width_e;

    function automatic logic [1:0] unit_shift(input logic [1:0] wcode);
        case (wcode)
            2'd0:    unit_shift = 2'd0;
            2'd1:    unit_shift = 2'd1;
            default: unit_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/lbs_addr_step.sv
module lbs_addr_step
    import lbs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    wcode,
    output logic [AW-1:0] next_addr,
    output logic          at_quad
);

    localparam int UNIT_BITS = 2;

    logic [1:0]    shift;
    logic [AW-1:0] step;

    always_comb begin
        shift     = unit_shift(wcode);
        step      = AW'(1) << shift;
        next_addr = addr + step;
        case (shift)
            2'd0:    at_quad = (addr[UNIT_BITS-1:0] == 2'b11);
            2'd1:    at_quad = (addr[UNIT_BITS:1] == 2'b11);
            default: at_quad = (addr[UNIT_BITS+1:2] == 2'b11);
        endcase
    end

endmodule

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] load_val,
    output logic          expired
);

    logic [WW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - WW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R10: once loaded with a non-zero value, the count is not expired next cycle
    p_load_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/lbs_burst_seq.sv
module lbs_burst_seq
    import lbs_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_beats,
    input  logic          cfg_burst,
    input  logic          cfg_term_en,
    input  logic [1:0]    cfg_width,
    input  logic [WW-1:0] cfg_wait,
    input  logic          ready_n,
    input  logic          bterm_n,
    output logic          ads_n,
    output logic          blast_n,
    output logic [AW-1:0] la,
    output logic          busy,
    output logic          done
);

    typedef struct packed {
        lbs_state_e    state;
        logic [AW-1:0] addr;
        logic [CW-1:0] left;
        logic          burst;
        logic          term;
        logic [1:0]    wcode;
        logic [WW-1:0] waits;
        logic          done;
    } seq_regs_s;

    seq_regs_s r_d, r_q;

    logic [AW-1:0] next_addr;
    logic          at_quad;
    logic          wait_done;
    logic          term_hit;
    logic          ack;
    logic          burst_end;
    logic          final_word;
    logic          tmr_load;

    lbs_addr_step #(.AW(AW)) u_step (
        .addr      (r_q.addr),
        .wcode     (r_q.wcode),
        .next_addr (next_addr),
        .at_quad   (at_quad)
    );

    lbs_wait_timer #(.WW(WW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (r_q.waits),
        .expired  (wait_done)
    );

    always_comb begin
        final_word = (r_q.left == CW'(1));
        // single-beat modes end every beat; quad mode ends at the boundary
        burst_end  = !r_q.burst || (!r_q.term && at_quad);
        term_hit   = (r_q.state == ST_DATA) && wait_done && r_q.term && !bterm_n;
        ack        = (r_q.state == ST_DATA) && wait_done && (term_hit || !ready_n);
        tmr_load   = (r_q.state == ST_ADDR) || ack;

        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid && req_beats != '0) begin
                    r_d.state = ST_ADDR;
                    r_d.addr  = req_addr;
                    r_d.left  = req_beats;
                    r_d.burst = cfg_burst;
                    r_d.term  = cfg_term_en;
                    r_d.wcode = cfg_width;
                    r_d.waits = cfg_wait;
                end
            end
            ST_ADDR: begin
                r_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (ack) begin
                    r_d.left = r_q.left - CW'(1);
                    r_d.addr = next_addr;
                    if (final_word) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else if (term_hit || burst_end) begin
                        r_d.state = ST_ADDR;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, left: '0, burst: 1'b0,
                     term: 1'b0, wcode: 2'd0, waits: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ads_n   = !(r_q.state == ST_ADDR);
    assign blast_n = !((r_q.state == ST_DATA) && (final_word || burst_end));
    assign la      = r_q.addr;
    assign busy    = (r_q.state != ST_IDLE);
    assign done    = r_q.done;

    // R2: an accepted request is followed by an address strobe at its address
    p_accept_ads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_beats != '0) |=> (!ads_n && la == $past(req_addr)));

    // R10: while the wait timer runs, the beat address cannot move
    p_wait_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_DATA) && !wait_done) |=> $stable(la));

    // R8: a terminate with words left re-addresses at the next word
    p_term_readdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_DATA) && wait_done && r_q.term && !bterm_n && !final_word)
        |=> (!ads_n && la == $past(next_addr)));

    // R4: quad-mode burst reaching its boundary re-addresses
    p_quad_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_DATA) && r_q.burst && !r_q.term && at_quad && ack && !final_word)
        |=> !ads_n);

    // R12: done only comes with the block idle
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: strobe and last-beat never overlap
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ads_n && !blast_n));

endmodule

// File: tb/sim_lbs_burst_seq.sv
module sim_lbs_burst_seq;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_beats = '0;
    logic          cfg_burst = 1'b0;
    logic          cfg_term_en = 1'b0;
    logic [1:0]    cfg_width = 2'd2;
    logic [WW-1:0] cfg_wait = '0;
    logic          ready_n = 1'b1;
    logic          bterm_n = 1'b1;
    logic          ads_n, blast_n, busy, done;
    logic [AW-1:0] la;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_tag = "R1";

    lbs_burst_seq #(.AW(AW), .CW(CW), .WW(WW)) u0 (
        .clk, .rst_n, .req_valid, .req_addr, .req_beats, .cfg_burst,
        .cfg_term_en, .cfg_width, .cfg_wait, .ready_n, .bterm_n,
        .ads_n, .blast_n, .la, .busy, .done
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_phase;      // 0 idle, 1 address cycle, 2 data
    int m_addr, m_left, m_unit, m_wt, m_wset;
    bit m_b, m_t, m_done;

    function automatic bit m_last();
        bit quad_end;
        quad_end = ((m_addr / m_unit) % 4) == 3;
        return (m_left == 1) || !m_b || (!m_t && quad_end);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_addr = 0; m_left = 0; m_unit = 4;
            m_wt = 0; m_wset = 0; m_b = 0; m_t = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_phase == 0) begin
                if (req_valid && req_beats != 0) begin
                    m_phase = 1;
                    m_addr  = int'(req_addr);
                    m_left  = int'(req_beats);
                    m_b     = cfg_burst;
                    m_t     = cfg_term_en;
                    m_unit  = (cfg_width == 2'd0) ? 1 : (cfg_width == 2'd1) ? 2 : 4;
                    m_wset  = int'(cfg_wait);
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
                m_wt    = m_wset;
            end else begin
                if (m_wt > 0) begin
                    m_wt--;
                end else begin
                    bit tb, lastb;
                    tb    = m_t && !bterm_n;
                    lastb = m_last();
                    if (tb || !ready_n) begin
                        m_wt   = m_wset;
                        m_left--;
                        m_addr = (m_addr + m_unit) % (1 << AW);
                        if (m_left == 0) begin
                            m_phase = 0;
                            m_done  = 1;
                        end else if (tb || lastb) begin
                            m_phase = 1;
                        end
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0h expected %0h (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    // compare all outputs against the model at every falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(cur_tag, "ads_n",   int'(ads_n),   (m_phase == 1) ? 0 : 1);
            check(cur_tag, "blast_n", int'(blast_n), (m_phase == 2 && m_last()) ? 0 : 1);
            check(cur_tag, "la",      int'(la),      m_addr);
            check(cur_tag, "busy",    int'(busy),    (m_phase != 0) ? 1 : 0);
            check(cur_tag, "done",    int'(done),    m_done ? 1 : 0);
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic xfer(input string tag, input int addr, input int beats,
                        input bit b, input bit t, input int w, input int ws,
                        input int p_rdy, input int p_bt, input bit poke);
        @(negedge clk);
        cur_tag     = tag;
        req_valid   = 1'b1;
        req_addr    = AW'(addr);
        req_beats   = CW'(beats);
        cfg_burst   = b;
        cfg_term_en = t;
        cfg_width   = 2'(w);
        cfg_wait    = WW'(ws);
        ready_n     = 1'b1;
        bterm_n     = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (m_phase != 0) begin
            ready_n   = !($urandom_range(99) < p_rdy);
            bterm_n   = !($urandom_range(99) < p_bt);
            // R2: requests while busy must be ignored
            req_valid = poke && ($urandom_range(3) == 0);
            req_addr  = AW'($urandom_range(16'hffff));
            req_beats = CW'($urandom_range(1, 20));
            @(negedge clk);
        end
        req_valid = 1'b0;
        ready_n   = 1'b1;
        bterm_n   = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1", "ads_n",   int'(ads_n),   1);
        check("R1", "blast_n", int'(blast_n), 1);
        check("R1", "busy",    int'(busy),    0);
        check("R1", "done",    int'(done),    0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: zero-count request is ignored
        cur_tag   = "R2 zero count";
        req_valid = 1'b1; req_beats = '0; req_addr = AW'(16'h1234);
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        check("R2", "ads_n idle", int'(ads_n), 1);
        check("R2", "busy idle",  int'(busy),  0);

        xfer("R3 R12 single",            'h100, 5,  0, 0, 2, 0, 70,  0,  0);
        xfer("R3 R8 single-term",        'h140, 6,  0, 1, 2, 0, 50,  30, 0);
        xfer("R4 R5 R6 quad32",          'h104, 9,  1, 0, 2, 0, 100, 0,  0);
        xfer("R4 R5 R6 quad16",          'h202, 7,  1, 0, 1, 0, 80,  0,  0);
        xfer("R4 R5 R10 quad8",          'h301, 10, 1, 0, 0, 1, 90,  0,  0);
        xfer("R7 R8 cont32",             'h400, 12, 1, 1, 2, 0, 80,  20, 0);
        xfer("R9 both asserted",         'h500, 6,  1, 1, 2, 0, 100, 100, 0);
        xfer("R10 R8 wait3",             'h600, 8,  1, 1, 1, 3, 100, 50, 0);
        xfer("R11 term ignored",         'h700, 9,  1, 0, 2, 0, 60,  100, 0);
        xfer("R11 R3 single no-term",    'h720, 4,  0, 0, 0, 2, 100, 100, 0);
        xfer("R2 R12 busy pokes",        'h800, 11, 1, 1, 2, 1, 70,  15, 1);
        xfer("R5 R6 wrap top",           'hfffa, 5, 1, 0, 2, 0, 100, 0,  0);
        xfer("R12 one word",             'h900, 1,  1, 1, 0, 0, 100, 0,  0);

        for (int i = 0; i < 40; i++) begin
            xfer("R4 R7 R10 mix", int'($urandom_range(16'hffff)), int'($urandom_range(1, 24)),
                 1'($urandom_range(1)), 1'($urandom_range(1)), int'($urandom_range(3)),
                 int'($urandom_range(3)), int'($urandom_range(30, 100)),
                 int'($urandom_range(40)), 1'($urandom_range(1)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule